// File: doc/BRIEF.md
# Transparent Signature Register

This block is a register that is added to a data path which had no register, at a point that several feedback loops share. In functional mode it is invisible: a bypass multiplexer routes the data input straight to the data output with no flip-flop in the way, so the surrounding logic keeps its original timing in cycles. In test mode the multiplexer selects an internal bank of flip-flops instead. That bank acts as a multiple-input signature register (MISR). Because the output now comes from flip-flops, every loop that passes through this point is cut.

While in test mode, each clock edge shifts the register one place toward the MSB. The bit entering at the LSB is a linear feedback bit. The result is then XORed with the arriving data word. The register therefore compacts what the upstream logic delivers, and in the same cycle it presents a pseudorandom word to the downstream logic. Outside test mode the flip-flops keep their value. The feedback taps and the seed loaded by reset are parameters.

Top module: `tmisr_reg`

## Requirements
- R1: While reset (rstN low) is asserted, the register is loaded with the SEED parameter (default 8'h01). With testMode high, dataOut then shows SEED.
- R2: With testMode low, dataOut equals dataIn in the same cycle, with no clock edge in between. This holds for every value of dataIn.
- R3: With testMode low, clock edges leave the register unchanged. The held value is what dataOut shows as soon as testMode goes high again.
- R4: With testMode high, dataOut shows the register contents and does not depend on the current dataIn.
- R5: On each rising clock edge with testMode high, the register becomes {state[WIDTH-2:0], fb} XOR dataIn. Here fb is the XOR of the state bits whose positions are set in TAP_MASK; bit i of the mask selects state bit i. The default mask is 8'hB8, which selects bits 7, 5, 4 and 3.
- R6: A change of testMode reaches dataOut at once. The register first changes on the first rising edge that samples testMode high.
- R7: With the default WIDTH, taps and seed, and dataIn held at zero in test mode, the register runs through 255 distinct non-zero states. It first returns to SEED after exactly 255 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low, loads SEED |
| testMode | input | 1 | 1 = signature register mode, 0 = wire mode |
| dataIn | input | WIDTH | Data arriving from the upstream logic |
| dataOut | output | WIDTH | Data delivered to the downstream logic |

## Verification
The clocked properties assume two things about the inputs. First, testMode and dataIn change only between rising edges and are steady when an edge samples them. Second, reset has been applied once, so the register starts from SEED and not from an unknown value. The stimulus respects both assumptions: every input change is made on the falling edge, and each phase begins from an asserted reset. The wire-mode check sweeps all 256 values of dataIn, and the signature checks compare dataOut against a step-by-step model of the update rule.

// File: rtl/tmisr_pkg.sv
package tmisr_pkg;

  // Strobes from the mode control to the datapath
  typedef struct packed {
    logic advance;  // register takes its next state on this edge
    logic showReg;  // output multiplexer selects the register
  } tmisrStrobe_t;

endpackage

// File: rtl/tmisr_ctrl.sv
module tmisr_ctrl
  import tmisr_pkg::*;
(
  input  logic         testMode,
  output tmisrStrobe_t strobe
);

  // Mode decode is purely combinational so a mode change reaches the mux at once
  always_comb begin
    strobe.advance = testMode;
    strobe.showReg = testMode;
  end

endmodule

// File: rtl/tmisr_dp.sv
module tmisr_dp
  import tmisr_pkg::*;
#(
  parameter int unsigned       WIDTH    = 8,
  parameter logic [WIDTH-1:0]  TAP_MASK = 8'hB8,
  parameter logic [WIDTH-1:0]  SEED     = 8'h01
)(
  input  logic             clk,
  input  logic             rstN,
  input  tmisrStrobe_t     strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] state,
  output logic [WIDTH-1:0] dataOut
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [MSB:0] stateQ;
  logic [MSB:0] stateNext;
  logic [MSB:0] shiftIn;
  logic         feedback;

  assign feedback = ^(stateQ & TAP_MASK);

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    if (i == 0) begin : gLsb
      assign shiftIn[i] = feedback;
    end else begin : gUpper
      assign shiftIn[i] = stateQ[i-1];
    end
    assign stateNext[i] = shiftIn[i] ^ dataIn[i];
    assign dataOut[i]   = strobe.showReg ? stateQ[i] : dataIn[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SEED;
    end else if (strobe.advance) begin
      stateQ <= stateNext;
    end
  end

  assign state = stateQ;

endmodule

// File: rtl/tmisr_reg.sv
module tmisr_reg
  import tmisr_pkg::*;
#(
  parameter int unsigned       WIDTH    = 8,
  parameter logic [WIDTH-1:0]  TAP_MASK = 8'hB8,
  parameter logic [WIDTH-1:0]  SEED     = 8'h01
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             testMode,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  tmisrStrobe_t     strobe;
  logic [WIDTH-1:0] sigState;

  tmisr_ctrl uCtrl (
    .testMode (testMode),
    .strobe   (strobe)
  );

  tmisr_dp #(
    .WIDTH    (WIDTH),
    .TAP_MASK (TAP_MASK),
    .SEED     (SEED)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .state   (sigState),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/tmisr_reg_chk.sv
module tmisr_reg_chk #(
  parameter int unsigned WIDTH = 8
)(
  input logic             clk,
  input logic             rstN,
  input logic             testMode,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] dataOut,
  input logic [WIDTH-1:0] state
);

  // R2: wire behaviour outside test mode
  assert_wire_path_R2: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> (dataOut == dataIn));

  // R3: no change of the register across a wire-mode edge
  assert_hold_state_R3: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |=> $stable(state));

  // R4: output comes from the register in test mode
  assert_show_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (dataOut == state));

  // R5: with zero data the upper bits are a pure shift of the lower ones
  assert_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && (dataIn == '0)) |=> (state[WIDTH-1:1] == $past(state[WIDTH-2:0])));

  // R6: entering test mode shows the value held through wire mode
  assert_mode_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testMode) |-> (dataOut == $past(state)));

endmodule

bind tmisr_reg tmisr_reg_chk #(.WIDTH(WIDTH)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .testMode (testMode),
  .dataIn   (dataIn),
  .dataOut  (dataOut),
  .state    (sigState)
);

// File: tb/tmisr_reg_test.sv
`timescale 1ns/1ps
module tmisr_reg_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       testMode = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] expState;

  localparam logic [7:0] SEED_V = 8'h01;

  tmisr_reg #(.WIDTH(8), .TAP_MASK(8'hB8), .SEED(8'h01)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .testMode (testMode),
    .dataIn   (dataIn),
    .dataOut  (dataOut)
  );

  always #4 clk = ~clk;  // 125 MHz

  // Update rule from R5: taps at bits 7, 5, 4, 3
  function automatic logic [7:0] nextSig(logic [7:0] s, logic [7:0] d);
    logic fb;
    fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    return {s[6:0], fb} ^ d;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      finishRun();
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    testMode = 1'b1;
    dataIn = 8'h00;
    #1;
    check("R1 seed under reset", dataOut, SEED_V);
    @(negedge clk);
    rstN = 1'b1;
    expState = SEED_V;
  endtask

  initial begin
    int period;
    logic [7:0] d;
    doReset();

    // R2 sweep over every input value in wire mode, R3 across these edges
    testMode = 1'b0;
    for (int v = 0; v < 256; v++) begin
      dataIn = v[7:0];
      #1;
      check("R2 wire path", dataOut, v[7:0]);
      @(negedge clk);
    end

    // R3/R6: entering test mode shows held seed immediately
    dataIn = 8'h5A;
    testMode = 1'b1;
    #1;
    check("R3 held after wire mode", dataOut, SEED_V);

    // R4/R5: signature sequence under varied data
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      expState = nextSig(expState, dataIn);
      d = 8'((k * 37 + 11) ^ (k >> 2));
      dataIn = d;
      #1;
      check("R5 signature step", dataOut, expState);
      dataIn = ~d;
      #1;
      check("R4 output ignores data", dataOut, expState);
      dataIn = d;
    end

    // R6: switch to wire mode mid-run, then back
    @(negedge clk);
    expState = nextSig(expState, dataIn);
    testMode = 1'b0;
    dataIn = 8'hC3;
    #1;
    check("R6 immediate wire", dataOut, 8'hC3);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      dataIn = 8'(k * 29 + 3);
      #1;
      check("R2 wire mid-run", dataOut, 8'(k * 29 + 3));
    end
    @(negedge clk);
    testMode = 1'b1;
    dataIn = 8'h77;
    #1;
    check("R3 hold across wire mode", dataOut, expState);
    @(negedge clk);
    expState = nextSig(expState, 8'h77);
    #1;
    check("R6 first test edge", dataOut, expState);

    // R7: maximal period with zero data
    doReset();
    testMode = 1'b1;
    dataIn = 8'h00;
    period = 0;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      expState = nextSig(expState, 8'h00);
      #1;
      if (dataOut === 8'h00) check("R7 no zero state", dataOut, 8'h01);
      if (k == 100) check("R7 model match", dataOut, expState);
      if (dataOut === SEED_V) begin
        period = k;
        break;
      end
    end
    check("R7 period low byte", 8'(period), 8'd255);

    finishRun();
  end

endmodule